// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a serial memory front end and handles the write path of a 16K x 8 non-volatile array. When the front end decodes a write command it opens a transaction with the 16-bit address it received. Each complete data byte then arrives as a strobe, together with a per-byte "allowed" flag that a separate protection unit computes. Bytes go into a 64-entry page buffer. The byte pointer advances only within the page, so a long burst wraps to the start of the same page and overwrites bytes loaded earlier in that burst.

The commit starts only when the front end reports that chip select has risen, and only if at least one full byte was loaded. The block then enters a self-timed programming cycle that lasts a fixed number of clock cycles, set by a parameter. During that cycle it sweeps the page once. For every slot that was loaded and allowed, it issues a single write toward the array, and all other locations in the page keep their contents. At the end of the cycle it pulses a done flag, drops busy and clears the write-enable latch. While busy, it ignores every request from the front end.

Top module: `page_program_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `wel` and `arr_we` are all 0.
- R2: `xfer_start` opens a transaction only when `wel` is 1 and `busy` is 0. The page number is `xfer_addr[13:6]` and the starting byte slot is `xfer_addr[5:0]`. Bits 15:14 are ignored.
- R3: Each `byte_stb` in an open transaction stores `byte_data` in the current slot, then advances only the 6-bit slot. Slot 63 is followed by slot 0 of the same page, and a later byte replaces an earlier one in the same slot.
- R4: `cs_rise` in an open transaction that holds at least one byte raises `busy` at the next clock edge. `busy` then stays high for exactly `WRITE_CYCLES` cycles.
- R5: `cs_rise` when no byte has been loaded ends the transaction. No cycle starts, and `wel` keeps its value.
- R6: During a cycle, `arr_we` pulses exactly once for each slot whose latest loaded byte had `byte_allowed`=1, and never for any other slot. The pulses come in ascending slot order, with `arr_addr` = {page, slot} and `arr_data` = the latest byte loaded into that slot.
- R7: When the cycle ends, `busy` falls and `wel` clears on the same edge. `done` is high for exactly that one following cycle.
- R8: While `busy` is 1, `xfer_start`, `byte_stb`, `cs_rise`, `wel_set` and `wel_clr` have no effect.
- R9: When idle, `wel_set` sets `wel` and `wel_clr` clears it. If both are asserted in the same cycle, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| xfer_start | input | 1 | Open a write transaction at `xfer_addr` |
| xfer_addr | input | 16 | Start address of the transaction |
| byte_stb | input | 1 | One complete data byte is present |
| byte_data | input | 8 | Data byte |
| byte_allowed | input | 1 | 1 if this byte may be committed |
| cs_rise | input | 1 | Chip select has risen; ends the transaction |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Self-timed cycle in progress |
| done | output | 1 | One-cycle pulse when the cycle ends |
| arr_we | output | 1 | Byte write enable toward the array |
| arr_addr | output | 14 | Array address of the write |
| arr_data | output | 8 | Array write data |

## Verification
A corrupt slot pointer or page register shows up at the array port within the first 64 cycles of the next commit, as a write to the wrong `arr_addr` or with the wrong data. A wrong loaded or allowed mask shows up as a missing or extra `arr_we` pulse in that same sweep. A cycle counter that is off by even one shows up as a `busy` length different from `WRITE_CYCLES`, or as `done` arriving too early or too late. Because the stimulus includes bursts that wrap within the page, carry the highest address bits, and reload a slot with a different allowed flag, these faults surface within one transaction.

// File: rtl/ppu_pkg.sv
// Package: shared constants and the commit-phase type for the page program unit.
// Assumes: byte-wide array, 16-bit serial address; widths overridable at the top.
package ppu_pkg;

    localparam int unsigned XFER_AW_DEF = 16;   // serial address width
    localparam int unsigned MEM_AW_DEF  = 14;   // significant array address bits
    localparam int unsigned PAGE_AW_DEF = 6;    // byte-in-page bits (64-byte page)
    localparam int unsigned DATA_W_DEF  = 8;    // array word width

    // Phases of the self-timed cycle: idle, page sweep, remaining wait.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SWEEP = 2'd1,
        PH_WAIT  = 2'd2
    } ppu_phase_e;

endpackage

// File: rtl/ppu_page_buffer.sv
// Module: ppu_page_buffer
// Collects data bytes of one write transaction into a page-sized buffer.
// The slot pointer wraps within the page; loaded and allowed flags are kept
// per slot, the latest load of a slot replacing earlier data and flag.
// Assumes: open, byte and close strobes are single-cycle pulses from the
// serial front end; nothing is accepted while a commit is running.
module ppu_page_buffer #(
    parameter int unsigned XFER_AW = ppu_pkg::XFER_AW_DEF,
    parameter int unsigned MEM_AW  = ppu_pkg::MEM_AW_DEF,
    parameter int unsigned PAGE_AW = ppu_pkg::PAGE_AW_DEF,
    parameter int unsigned DATA_W  = ppu_pkg::DATA_W_DEF,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_AW,
    localparam int unsigned PG_W       = MEM_AW - PAGE_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               wel,
    input  logic               open_req,
    input  logic [XFER_AW-1:0] open_addr,
    input  logic               byte_stb,
    input  logic [DATA_W-1:0]  byte_val,
    input  logic               byte_ok,
    input  logic               close_req,
    input  logic [PAGE_AW-1:0] rd_slot,
    output logic               start,
    output logic [PG_W-1:0]    page,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_commit
);

    logic                   active_q;
    logic [PG_W-1:0]        page_q;
    logic [PAGE_AW-1:0]     slot_q;
    logic [PAGE_BYTES-1:0]  ld_q;
    logic [PAGE_BYTES-1:0]  ok_q;
    logic [DATA_W-1:0]      mem_q [PAGE_BYTES];

    logic open_en;
    logic load_en;
    logic close_en;

    // Request qualification: opening needs an idle unit with the latch set.
    always_comb begin
        open_en  = open_req && !busy && wel;
        load_en  = byte_stb && active_q && !busy && !open_en;
        close_en = close_req && active_q && !open_en;
    end

    // Transaction control: page capture, slot pointer, open/closed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            page_q   <= '0;
            slot_q   <= '0;
        end else if (open_en) begin
            active_q <= 1'b1;
            page_q   <= open_addr[MEM_AW-1:PAGE_AW];
            slot_q   <= open_addr[PAGE_AW-1:0];
        end else if (close_en) begin
            active_q <= 1'b0;
        end else if (load_en) begin
            slot_q   <= slot_q + 1'b1;
        end
    end

    // Per-slot loaded and allowed flags, cleared when a transaction opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '0;
            ok_q <= '0;
        end else if (open_en) begin
            ld_q <= '0;
            ok_q <= '0;
        end else if (load_en) begin
            ld_q[slot_q] <= 1'b1;
            ok_q[slot_q] <= byte_ok;
        end
    end

    // Data storage; contents only matter where the loaded flag is set.
    always_ff @(posedge clk) begin
        if (load_en) begin
            mem_q[slot_q] <= byte_val;
        end
    end

    // Commit request and read port toward the sweep.
    always_comb begin
        start     = close_en && (|ld_q);
        page      = page_q;
        rd_data   = mem_q[rd_slot];
        rd_commit = ld_q[rd_slot] && ok_q[rd_slot];
    end

    // R8: a transaction is never open while a commit runs.
    a_r8_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !active_q);

    // R3: page number holds for the whole open transaction.
    a_r3_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !open_req) |=> $stable(page_q));

endmodule

// File: rtl/ppu_write_timer.sv
// Module: ppu_write_timer
// Self-timed programming cycle: a sweep phase of one cycle per page slot,
// then a wait until WRITE_CYCLES cycles have elapsed in total.
// Assumes: WRITE_CYCLES exceeds the page size; start only arrives when idle.
module ppu_write_timer #(
    parameter int unsigned PAGE_AW      = ppu_pkg::PAGE_AW_DEF,
    parameter int unsigned WRITE_CYCLES = 500000,
    localparam int unsigned PAGE_BYTES = 1 << PAGE_AW,
    localparam int unsigned CNT_W      = $clog2(WRITE_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               sweeping,
    output logic               finish,
    output logic               done,
    output logic [PAGE_AW-1:0] slot
);
    import ppu_pkg::*;

    localparam logic [CNT_W-1:0] SWEEP_LAST = CNT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] CYCLE_LAST = CNT_W'(WRITE_CYCLES - 1);

    ppu_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Phase and elapsed-cycle counter of the programming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_SWEEP;
                        cnt_q   <= '0;
                    end
                end
                PH_SWEEP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == SWEEP_LAST) begin
                        phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CYCLE_LAST) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Status decode for the rest of the unit.
    always_comb begin
        busy     = (phase_q != PH_IDLE);
        sweeping = (phase_q == PH_SWEEP);
        finish   = (phase_q == PH_WAIT) && (cnt_q == CYCLE_LAST);
        done     = done_q;
        slot     = cnt_q[PAGE_AW-1:0];
    end

    // R4: a start from idle begins the cycle at count zero.
    a_r4_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cnt_q == '0));

    // R4: busy cannot drop before the final count.
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);

    // R7: done is a single-cycle pulse outside the busy window.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/ppu_commit_sweep.sv
// Module: ppu_commit_sweep
// Turns the buffer slot under the sweep into an array write when that slot
// was loaded and allowed; forms the full array address from page and slot.
// Assumes: slot advances once per cycle during the sweep phase.
module ppu_commit_sweep #(
    parameter int unsigned MEM_AW  = ppu_pkg::MEM_AW_DEF,
    parameter int unsigned PAGE_AW = ppu_pkg::PAGE_AW_DEF,
    parameter int unsigned DATA_W  = ppu_pkg::DATA_W_DEF,
    localparam int unsigned PG_W   = MEM_AW - PAGE_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sweeping,
    input  logic [PAGE_AW-1:0] slot,
    input  logic [PG_W-1:0]    page,
    input  logic               slot_commit,
    input  logic [DATA_W-1:0]  slot_data,
    output logic               we,
    output logic [MEM_AW-1:0]  addr,
    output logic [DATA_W-1:0]  data
);

    // Write strobe, address and data toward the array.
    always_comb begin
        we   = sweeping && slot_commit;
        addr = {page, slot};
        data = slot_data;
    end

    // R6: consecutive sweep cycles visit ascending slots.
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && $past(sweeping)) |-> (slot == $past(slot) + 1'b1));

    // R6: page part of the address is constant during the sweep.
    a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && $past(sweeping)) |-> $stable(page));

endmodule

// File: rtl/page_program_unit.sv
// Module: page_program_unit (top)
// Page write buffer with a self-timed commit toward a 16K x 8 array.
// Holds the write-enable latch, which the end of each cycle clears.
// Assumes: front-end strobes are one-cycle pulses in the clk domain;
// WRITE_CYCLES is larger than the page size.
module page_program_unit #(
    parameter int unsigned XFER_AW      = ppu_pkg::XFER_AW_DEF,
    parameter int unsigned MEM_AW       = ppu_pkg::MEM_AW_DEF,
    parameter int unsigned PAGE_AW      = ppu_pkg::PAGE_AW_DEF,
    parameter int unsigned DATA_W       = ppu_pkg::DATA_W_DEF,
    parameter int unsigned WRITE_CYCLES = 500000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wel_set,
    input  logic               wel_clr,
    input  logic               xfer_start,
    input  logic [XFER_AW-1:0] xfer_addr,
    input  logic               byte_stb,
    input  logic [DATA_W-1:0]  byte_data,
    input  logic               byte_allowed,
    input  logic               cs_rise,
    output logic               wel,
    output logic               busy,
    output logic               done,
    output logic               arr_we,
    output logic [MEM_AW-1:0]  arr_addr,
    output logic [DATA_W-1:0]  arr_data
);

    localparam int unsigned PG_W = MEM_AW - PAGE_AW;

    logic               wel_q;
    logic               t_busy;
    logic               t_sweeping;
    logic               t_finish;
    logic               t_done;
    logic [PAGE_AW-1:0] t_slot;
    logic               b_start;
    logic [PG_W-1:0]    b_page;
    logic [DATA_W-1:0]  b_data;
    logic               b_commit;

    // Write-enable latch: set/clear when idle, cleared when a cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (t_finish) begin
            wel_q <= 1'b0;
        end else if (!t_busy) begin
            if (wel_clr) begin
                wel_q <= 1'b0;
            end else if (wel_set) begin
                wel_q <= 1'b1;
            end
        end
    end

    ppu_page_buffer #(
        .XFER_AW (XFER_AW),
        .MEM_AW  (MEM_AW),
        .PAGE_AW (PAGE_AW),
        .DATA_W  (DATA_W)
    ) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (t_busy),
        .wel       (wel_q),
        .open_req  (xfer_start),
        .open_addr (xfer_addr),
        .byte_stb  (byte_stb),
        .byte_val  (byte_data),
        .byte_ok   (byte_allowed),
        .close_req (cs_rise),
        .rd_slot   (t_slot),
        .start     (b_start),
        .page      (b_page),
        .rd_data   (b_data),
        .rd_commit (b_commit)
    );

    ppu_write_timer #(
        .PAGE_AW      (PAGE_AW),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (b_start),
        .busy     (t_busy),
        .sweeping (t_sweeping),
        .finish   (t_finish),
        .done     (t_done),
        .slot     (t_slot)
    );

    ppu_commit_sweep #(
        .MEM_AW  (MEM_AW),
        .PAGE_AW (PAGE_AW),
        .DATA_W  (DATA_W)
    ) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .sweeping    (t_sweeping),
        .slot        (t_slot),
        .page        (b_page),
        .slot_commit (b_commit),
        .slot_data   (b_data),
        .we          (arr_we),
        .addr        (arr_addr),
        .data        (arr_data)
    );

    // Port drive.
    always_comb begin
        wel  = wel_q;
        busy = t_busy;
        done = t_done;
    end

    // R7: the latch is already clear when done is reported.
    a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wel);

    // R8: the latch cannot move during a cycle except at its end.
    a_r8_wel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !t_finish) |=> $stable(wel));

    // R6: array writes happen only inside the busy window.
    a_r6_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (busy && !done));

    // R1: reset leaves every output flag low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done && !wel && !arr_we));

endmodule

// File: tb/test_page_program_unit.sv
module test_page_program_unit;

    localparam int WC = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wel_set = 0, wel_clr = 0, xfer_start = 0, byte_stb = 0;
    logic        byte_allowed = 0, cs_rise = 0;
    logic [15:0] xfer_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        wel, busy, done, arr_we;
    logic [13:0] arr_addr;
    logic [7:0]  arr_data;

    page_program_unit #(.WRITE_CYCLES(WC)) i_page_program_unit (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .byte_stb(byte_stb),
        .byte_data(byte_data), .byte_allowed(byte_allowed), .cs_rise(cs_rise),
        .wel(wel), .busy(busy), .done(done), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data)
    );

    always #5 clk = ~clk;

    // Vector: {addr[15:0], nbytes[7:0], seed[7:0], allow_mask[7:0], exp_writes[7:0]}
    // byte i carries seed+i and allowed = allow_mask[i % 7]
    localparam logic [47:0] VEC [8] = '{
        {16'h0010, 8'd1,  8'hA5, 8'hFF, 8'd1 },
        {16'h0105, 8'd4,  8'h10, 8'hFF, 8'd4 },
        {16'h3FFE, 8'd4,  8'h20, 8'hFF, 8'd4 },
        {16'hC040, 8'd64, 8'h00, 8'hFF, 8'd64},
        {16'h2020, 8'd70, 8'h80, 8'hFF, 8'd64},
        {16'h1000, 8'd8,  8'h40, 8'hAA, 8'd3 },
        {16'h0200, 8'd3,  8'h55, 8'h00, 8'd0 },
        {16'h0400, 8'd66, 8'h00, 8'h01, 8'd9 }
    };

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Monitor state (monotonic counters, written only here).
    int mon_wr = 0, mon_busy = 0, mon_done = 0, mon_order_err = 0;
    int last_slot = -1;
    logic [7:0] obs_data  [int];
    int         obs_stamp [int];

    always @(negedge clk) begin
        if (arr_we) begin
            mon_wr++;
            obs_data[int'(arr_addr)]  = arr_data;
            obs_stamp[int'(arr_addr)] = mon_wr;
            if (int'(arr_addr[5:0]) <= last_slot) mon_order_err++;
            last_slot = int'(arr_addr[5:0]);
        end
        if (!busy) last_slot = -1;
        if (busy) mon_busy++;
        if (done) mon_done++;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_wel(bit s, bit c);
        wel_set = s; wel_clr = c;
        tick();
        wel_set = 0; wel_clr = 0;
    endtask

    task automatic load_txn(logic [15:0] a, int n, logic [7:0] seed, logic [7:0] am);
        xfer_start = 1; xfer_addr = a;
        tick();
        xfer_start = 0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1; byte_data = seed + 8'(i); byte_allowed = am[i % 7];
            tick();
        end
        byte_stb = 0;
        cs_rise = 1;
        tick();
        cs_rise = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < WC + 20 && (busy || done); k++) tick();
        repeat (3) tick();
    endtask

    // Apply one transaction and compare against the requirement model.
    task automatic run_vec(int idx, logic [15:0] a, int n, logic [7:0] seed,
                           logic [7:0] am, int expw);
        int base_wr, base_busy, base_done, base_err, nmodel;
        logic [7:0] m_data [64];
        bit m_ld [64];
        bit m_ok [64];
        for (int s = 0; s < 64; s++) begin m_ld[s] = 0; m_ok[s] = 0; m_data[s] = 0; end
        for (int i = 0; i < n; i++) begin
            int s = (int'(a[5:0]) + i) % 64;
            m_ld[s] = 1; m_ok[s] = am[i % 7]; m_data[s] = seed + 8'(i);
        end
        nmodel = 0;
        for (int s = 0; s < 64; s++) if (m_ld[s] && m_ok[s]) nmodel++;
        base_wr = mon_wr; base_busy = mon_busy; base_done = mon_done; base_err = mon_order_err;
        pulse_wel(1, 0);
        load_txn(a, n, seed, am);
        wait_idle();
        chk($sformatf("R6 vec%0d write count (table)", idx), mon_wr - base_wr, expw);
        chk($sformatf("R6 vec%0d write count (model)", idx), mon_wr - base_wr, nmodel);
        chk($sformatf("R6 vec%0d ascending order", idx), mon_order_err - base_err, 0);
        for (int s = 0; s < 64; s++) begin
            if (m_ld[s] && m_ok[s]) begin
                int ad = int'({a[13:6], 6'(s)});
                bit hit = obs_stamp.exists(ad) && obs_stamp[ad] > base_wr;
                chk($sformatf("R2 R3 vec%0d slot %0d written", idx, s), int'(hit), 1);
                if (hit)
                    chk($sformatf("R3 R6 vec%0d slot %0d data", idx, s),
                        int'(obs_data[ad]), int'(m_data[s]));
            end
        end
        chk($sformatf("R4 vec%0d busy length", idx), mon_busy - base_busy, WC);
        chk($sformatf("R7 vec%0d done pulses", idx), mon_done - base_done, 1);
        chk($sformatf("R7 vec%0d wel cleared", idx), int'(wel), 0);
    endtask

    initial begin
        int bw, bb, bd;
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 wel", int'(wel), 0);
        chk("R1 arr_we", int'(arr_we), 0);

        for (int v = 0; v < 8; v++) begin
            run_vec(v, VEC[v][47:32], int'(VEC[v][31:24]), VEC[v][23:16],
                    VEC[v][15:8], int'(VEC[v][7:0]));
        end

        // R9: set, then set+clear together (clear wins)
        pulse_wel(1, 0);
        chk("R9 wel set", int'(wel), 1);
        pulse_wel(1, 1);
        chk("R9 clear wins", int'(wel), 0);

        // R2: transaction without latch is not accepted
        bb = mon_busy;
        load_txn(16'h0300, 2, 8'h11, 8'hFF);
        repeat (5) tick();
        chk("R2 no wel no cycle", mon_busy - bb, 0);

        // R5: close with no byte loaded
        pulse_wel(1, 0);
        bb = mon_busy;
        xfer_start = 1; xfer_addr = 16'h0500;
        tick();
        xfer_start = 0; cs_rise = 1;
        tick();
        cs_rise = 0;
        repeat (5) tick();
        chk("R5 no cycle", mon_busy - bb, 0);
        chk("R5 wel kept", int'(wel), 1);

        // R8: requests during busy are ignored
        bw = mon_wr; bb = mon_busy; bd = mon_done;
        load_txn(16'h0600, 2, 8'h31, 8'hFF);
        repeat (70) tick();
        chk("R8 still busy", int'(busy), 1);
        pulse_wel(0, 1);
        chk("R8 wel_clr ignored", int'(wel), 1);
        load_txn(16'h0700, 1, 8'h77, 8'hFF);
        wait_idle();
        repeat (10) tick();
        chk("R8 only first txn written", mon_wr - bw, 2);
        chk("R8 one busy window", mon_busy - bb, WC);
        chk("R8 one done", mon_done - bd, 1);
        chk("R8 R7 wel cleared at end", int'(wel), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule